// File: doc/BRIEF.md
# I2C Register Target with Saturating Address Pointer

This block is an I2C target that exposes a small byte-wide register file, addresses 00h to 16h, to a fast-mode bus master. It runs entirely on the system clock. SCL and SDA pass through a synchroniser and are edge-detected, and the block drives SDA only through an open-drain pull-low enable. On the register side it has one address output, a single-cycle write strobe with its data, and a read-data input that the surrounding register file supplies combinationally for the presented address.

A write transaction carries the device address with the direction bit clear, then one pointer byte, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then moves forward. A read transaction returns bytes starting at the current pointer and advances after each byte. A combined read is a pointer write, a repeated start and a read address. The pointer never wraps: once it reaches the top register it stays there. Because the pointer keeps its value between transactions, a read that is not preceded by a pointer byte continues from the address after the last one accessed.

Top module: `regbus_i2c_target`

## Requirements
- R1: After reset the SDA pull-low enable is inactive, no register write strobe is issued and the register address output reads 00h.
- R2: A rising SDA while SCL is high (stop) ends the transaction. Bytes clocked after a stop without a new start are not acknowledged and write nothing.
- R3: The device address is 63h, sent in the upper seven bits of the first byte after a start, with bit 0 as the direction (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the block then ignores every byte until the next start.
- R4: In a write, the first byte after the address loads the pointer. A value above 16h loads 16h.
- R5: Each further byte in a write is stored at the pointer with one write strobe, and the pointer then moves up by one.
- R6: The pointer stops at 16h for both writes and reads, so further bytes keep writing or returning register 16h.
- R7: A read that directly follows the address byte starts at the pointer left by the previous access, which is the address after the last one written or read, or the value just loaded by a pointer byte.
- R8: A repeated start followed by the read address returns data from the pointer set before it. A repeated start followed by the write address begins a new pointer-and-data write.
- R9: In a read the block drives each byte MSB first. If the master does not acknowledge, the block releases SDA and stays silent until a start or stop, so further clocks read all ones.
- R10: The block changes its SDA drive only while SCL is low.
- R11: Every pointer byte and every data byte of an addressed write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock level as seen on the wire |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| sdaDriveLow | output | 1 | When high, the pad pulls SDA low |
| regAddr | output | 5 | Register pointer, used as write and read address |
| regWrEn | output | 1 | One-cycle write strobe into the register file |
| regWrData | output | 8 | Byte to store when regWrEn is high |
| regRdData | input | 8 | Register file contents at regAddr |

## Verification
The assertions take for granted a well-behaved master. It never makes SDA rise or fall while SCL is high except to form a start or stop. It never issues a stop while the target is pulling SDA low. Its SCL phases last several system clocks longer than the synchroniser delay. The stimulus keeps to these rules by building every bus event from quarter-bit steps of eight system clocks, with data changes placed only in the low phase. It also releases SDA whenever the target owns the line.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_WDATA,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } ctrlState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic bumpPtr;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic releaseSda;
  } dpCmd_t;

  // Bus events from the datapath to the control FSM
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLevel;
  } busEv_t;

endpackage

// File: rtl/regbus_dp.sv
module regbus_dp
  import regbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int PTR_W       = 5,
  parameter int TOP_ADDR    = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  input  logic [BYTE_W-1:0] regRdData,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              sdaDriveLow
);

  localparam logic [PTR_W-1:0]  PTR_TOP  = PTR_W'(TOP_ADDR);
  localparam logic [BYTE_W-1:0] BYTE_TOP = BYTE_W'(TOP_ADDR);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0]  ptr;
  logic              drvLow;

  // Bus synchroniser, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.sclRise   = sclNow & ~sclPrev;
    ev.sclFall   = ~sclNow & sclPrev;
    ev.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaLevel  = sdaNow;
  end

  // Receive shifter and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (cmd.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaNow};
      if (cmd.loadTx)       txShift <= regRdData;
      else if (cmd.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  // Register pointer, clamped on load and saturating on advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (cmd.loadPtr) begin
      if (rxShift > BYTE_TOP) ptr <= PTR_TOP;
      else                    ptr <= rxShift[PTR_W-1:0];
    end else if (cmd.bumpPtr && (ptr < PTR_TOP)) begin
      ptr <= ptr + 1'b1;
    end
  end

  // Open-drain pull-low enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               drvLow <= 1'b0;
    else if (cmd.loadTx)     drvLow <= ~regRdData[BYTE_W-1];
    else if (cmd.shiftTx)    drvLow <= ~txShift[BYTE_W-2];
    else if (cmd.driveAck)   drvLow <= 1'b1;
    else if (cmd.releaseSda) drvLow <= 1'b0;
  end

  assign rxByte      = rxShift;
  assign regAddr     = ptr;
  assign regWrEn     = cmd.writeReg;
  assign regWrData   = rxShift;
  assign sdaDriveLow = drvLow;

  AST_PTR_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_TOP); // R6

  AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cmd.loadPtr) && (ptr != $past(ptr))) |-> (ptr == $past(ptr) + 1'b1)); // R5

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (drvLow != $past(drvLow)) |-> !$past(sclNow)); // R10

endmodule

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h63
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCmd_t            cmd,
  output logic              quiet
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  ctrlState_t st, stNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic isRead, rdNxt, mAck, ackNxt;
  logic byteDone, addrHit;

  assign byteDone = (bitCnt == LAST_BIT);
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);

  always_comb begin
    cmd    = '0;
    stNxt  = st;
    cntNxt = bitCnt;
    rdNxt  = isRead;
    ackNxt = mAck;
    if (ev.stopSeen) begin
      stNxt = ST_IDLE;
      cmd.releaseSda = 1'b1;
      cntNxt = '0;
    end else if (ev.startSeen) begin
      stNxt = ST_ADDR;
      cmd.releaseSda = 1'b1;
      cntNxt = '0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (ev.sclRise) begin
            cmd.shiftIn = 1'b1;
            cntNxt = bitCnt + 1'b1;
          end else if (ev.sclFall && byteDone) begin
            cntNxt = '0;
            if (st == ST_ADDR) begin
              if (addrHit) begin
                cmd.driveAck = 1'b1;
                rdNxt = rxByte[0];
                stNxt = ST_ADDR_ACK;
              end else begin
                stNxt = ST_IGNORE;
              end
            end else begin
              cmd.driveAck = 1'b1;
              stNxt = ST_RX_ACK;
              if (st == ST_PTR) begin
                cmd.loadPtr = 1'b1;
              end else begin
                cmd.writeReg = 1'b1;
                cmd.bumpPtr  = 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            if (isRead) begin
              cmd.loadTx = 1'b1;
              stNxt = ST_TX;
            end else begin
              cmd.releaseSda = 1'b1;
              stNxt = ST_PTR;
            end
          end
        end
        ST_RX_ACK: begin
          if (ev.sclFall) begin
            cmd.releaseSda = 1'b1;
            stNxt = ST_WDATA;
          end
        end
        ST_TX: begin
          if (ev.sclRise) begin
            cntNxt = bitCnt + 1'b1;
          end else if (ev.sclFall) begin
            if (byteDone) begin
              cmd.releaseSda = 1'b1;
              cmd.bumpPtr = 1'b1;
              cntNxt = '0;
              stNxt = ST_TX_ACK;
            end else begin
              cmd.shiftTx = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (ev.sclRise) begin
            ackNxt = ~ev.sdaLevel;
          end else if (ev.sclFall) begin
            if (mAck) begin
              cmd.loadTx = 1'b1;
              stNxt = ST_TX;
            end else begin
              stNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      st     <= stNxt;
      bitCnt <= cntNxt;
      isRead <= rdNxt;
      mAck   <= ackNxt;
    end
  end

  assign quiet = (st == ST_IDLE) || (st == ST_IGNORE);

  AST_WRITE_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    cmd.writeReg |-> ev.sclFall); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopSeen |=> quiet); // R2

  AST_ONE_PTR_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadPtr, cmd.bumpPtr})); // R4

endmodule

// File: rtl/regbus_i2c_target.sv
module regbus_i2c_target
  import regbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h63,
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         PTR_W       = 5,
  parameter int         TOP_ADDR    = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);

  dpCmd_t            cmd;
  busEv_t            ev;
  logic [BYTE_W-1:0] rxByte;
  logic              quiet;

  regbus_ctrl #(
    .BYTE_W  (BYTE_W),
    .DEV_ADDR(DEV_ADDR)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .ev    (ev),
    .rxByte(rxByte),
    .cmd   (cmd),
    .quiet (quiet)
  );

  regbus_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W     (BYTE_W),
    .PTR_W      (PTR_W),
    .TOP_ADDR   (TOP_ADDR)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .cmd        (cmd),
    .regRdData  (regRdData),
    .ev         (ev),
    .rxByte     (rxByte),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .sdaDriveLow(sdaDriveLow)
  );

  AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    quiet |-> !sdaDriveLow); // R3

  AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    quiet |-> !regWrEn); // R2

endmodule

// File: tb/regbus_i2c_target_test.sv
module regbus_i2c_target_test;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam logic [7:0] AW = 8'hC6;
  localparam logic [7:0] AR = 8'hC7;
  localparam int NVEC = 6;
  // {pointer, data}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h005A, 16'h01A5, 16'h073C, 16'h0CFF, 16'h1081, 16'h1642
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow, regWrEn;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic sdaBus;
  logic [7:0] mem [23];
  int testsRun = 0, testsFailed = 0, wrCount = 0, highMoves = 0;
  logic done = 1'b0;
  logic prevDrv = 1'b0, prevScl = 1'b1;

  assign sdaBus = sdaM & ~sdaDriveLow;
  assign regRdData = (regAddr < 5'd23) ? mem[regAddr] : 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbus_i2c_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 23; i++) mem[i] <= 8'h00;
    end else if (regWrEn && regAddr < 5'd23) begin
      mem[regAddr] <= regWrData;
    end
  end

  always @(posedge clk) begin
    if (rstN && regWrEn) wrCount <= wrCount + 1;
    if (rstN && sclM && prevScl && (sdaDriveLow != prevDrv)) highMoves <= highMoves + 1;
    prevDrv <= sdaDriveLow;
    prevScl <= sclM;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ();
    s = sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(~giveAck, s);
  endtask

  task automatic writeRegs(input logic [7:0] p, input logic [7:0] d);
    logic a;
    busStart(); writeByte(AW, a); writeByte(p, a); writeByte(d, a); busStop();
  endtask

  initial begin
    logic a0, a1, a2;
    logic [7:0] d0, d1, d2;
    int wrBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 drive", sdaDriveLow, 0);
    check("R1 wrEn", regWrEn, 0);
    check("R1 addr", regAddr, 0);

    // Table: write one byte, read it back by combined read
    for (int v = 0; v < NVEC; v++) begin
      busStart();
      writeByte(AW, a0); writeByte(VEC[v][15:8], a1); writeByte(VEC[v][7:0], a2);
      busStop();
      if (v == 0) begin
        check("R3 addr ack", a0, 1);
        check("R11 ptr ack", a1, 1);
        check("R11 data ack", a2, 1);
      end
      check("R5 stored", mem[VEC[v][12:8]], VEC[v][7:0]);
      busStart(); writeByte(AW, a0); writeByte(VEC[v][15:8], a1);
      busStart(); writeByte(AR, a2); readByte(1'b0, d0); busStop();
      check("R8 combined read", d0, VEC[v][7:0]);
    end

    // R6 write saturation at 16h
    wrBefore = wrCount;
    busStart(); writeByte(AW, a0); writeByte(8'h14, a0);
    writeByte(8'h11, a0); writeByte(8'h22, a0); writeByte(8'h33, a0); writeByte(8'h44, a0);
    busStop();
    check("R6 reg14", mem[20], 8'h11);
    check("R6 reg15", mem[21], 8'h22);
    check("R6 reg16 last", mem[22], 8'h44);
    check("R5 strobes", wrCount - wrBefore, 4);

    // R7 current-address read continues after last access
    writeRegs(8'h04, 8'h9E);
    writeRegs(8'h05, 8'h6B);
    writeRegs(8'h03, 8'h77);
    busStart(); writeByte(AR, a0); readByte(1'b1, d0); readByte(1'b0, d1); busStop();
    check("R7 first", d0, 8'h9E);
    check("R7 second", d1, 8'h6B);
    busStart(); writeByte(AR, a0); readByte(1'b0, d0); busStop();
    check("R7 after read", d0, 8'h00);

    // R6 read saturation
    busStart(); writeByte(AW, a0); writeByte(8'h15, a0);
    busStart(); writeByte(AR, a0);
    readByte(1'b1, d0); readByte(1'b1, d1); readByte(1'b0, d2); busStop();
    check("R6 read 15", d0, 8'h22);
    check("R6 read 16", d1, 8'h44);
    check("R6 read 16 again", d2, 8'h44);

    // R4 pointer clamp
    writeRegs(8'h7F, 8'h5C);
    check("R4 clamp", mem[22], 8'h5C);

    // R8 repeated start continues as write
    busStart(); writeByte(AW, a0); writeByte(8'h02, a0);
    busStart(); writeByte(AW, a0); writeByte(8'h09, a0); writeByte(8'hD1, a0); busStop();
    check("R8 rewrite target", mem[9], 8'hD1);
    check("R8 first ptr untouched", mem[2], 8'h00);

    // R3 address mismatch
    wrBefore = wrCount;
    busStart(); writeByte(8'hA4, a0); writeByte(8'h03, a1); writeByte(8'hEE, a2); busStop();
    check("R3 no addr ack", a0, 0);
    check("R3 no later ack", a1 | a2, 0);
    check("R3 no write", wrCount - wrBefore, 0);
    check("R3 reg kept", mem[3], 8'h77);

    // R9 master nack releases the line
    busStart(); writeByte(AW, a0); writeByte(8'h09, a0);
    busStart(); writeByte(AR, a0); readByte(1'b0, d0); readByte(1'b0, d1); busStop();
    check("R9 data", d0, 8'hD1);
    check("R9 released", d1, 8'hFF);

    // R2 bytes after a stop are ignored
    wrBefore = wrCount;
    writeByte(AW, a0); writeByte(8'h00, a1); writeByte(8'h99, a2); busStop();
    check("R2 no ack", a0 | a1 | a2, 0);
    check("R2 no write", wrCount - wrBefore, 0);

    // R10 drive never moved with SCL high
    check("R10 moves", highMoves, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule